// File: doc/BRIEF.md
# DRAM Strobe Cycle Decoder

This block is the control front end of an asynchronous 1M x 4 DRAM. It watches the row strobe, column strobe, write enable and output enable pins, and it sorts each row cycle into a kind from the order in which those pins change. The kinds are read, early write, late (read-modify) write, row-only refresh, column-before-row refresh and hidden refresh. A fast system clock samples all pins. An edge is found by comparing each sample with the one before it.

From that classification the block drives four things to the array: the row address with a one-cycle latch pulse, a one-cycle strobe that captures write data, the enable for the DQ output drivers, and a cycle type code. For refresh cycles where the column strobe is already low, the block ignores the external address. A 10-bit refresh row counter inside the block supplies the row instead.

Top module: `dram_strobe_decoder`

## Requirements
- R1: After reset, `cyc_type` is 0 (idle), `dq_oe`, `row_stb` and `din_stb` are low, and the refresh counter holds row 0.
- R2: A row strobe fall with the column strobe high gives a single-cycle `row_stb` pulse, with `row_addr` equal to the external row input. If the column strobe does not fall before the row strobe rises, `cyc_type` reads 4 (row-only refresh) and `dq_oe` stays low.
- R3: A column strobe fall inside an open row with write enable high sets `cyc_type` to 1 (read). `dq_oe` then equals the inverse of `oe_n`, and no `din_stb` pulse occurs.
- R4: After the column strobe rises in a read, `dq_oe` keeps following `oe_n`. It is cleared when both strobes are high, and it is cleared when write enable falls while the column strobe is high.
- R5: Write enable low at the column strobe fall sets `cyc_type` to 2 (early write). Exactly one `din_stb` pulse follows that column fall, and `dq_oe` stays low whatever the value of `oe_n`.
- R6: Write enable falling while the column strobe is low in a read sets `cyc_type` to 3 (late write). Exactly one `din_stb` pulse follows that write-enable fall, none follows the earlier column fall, and `dq_oe` goes low.
- R7: A row strobe fall with the column strobe already low and no read held open sets `cyc_type` to 5 (column-before-row refresh). `row_addr` comes from the refresh counter, and the external row input is ignored.
- R8: While the column strobe stays low, every further row strobe pulse is another column-before-row refresh with the next counter row.
- R9: A read whose column strobe stays low while the row strobe cycles gives `cyc_type` 6 (hidden refresh). `row_addr` comes from the counter, and `dq_oe` stays high with `oe_n` low.
- R10: The refresh counter advances by one after each counter-addressed refresh and wraps from 1023 to 0.
- R11: Outputs are registered. A pin change sampled at one clock edge shows on the outputs after the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| row_in | input | 10 | External row address |
| row_addr | output | 10 | Row selected for the array |
| row_stb | output | 1 | One-cycle row latch pulse |
| din_stb | output | 1 | One-cycle write data capture pulse |
| dq_oe | output | 1 | DQ output driver enable |
| cyc_type | output | 3 | Cycle type code |

## Verification
A wrong refresh counter shows on `row_addr` at the very next counter-addressed refresh, which is two clock edges after the row strobe falls. A lost or stuck read-valid state shows on `dq_oe` in the following output-enable window: at the extended hold after the column strobe rises, or across a hidden refresh. A misjudged edge order shows as an extra or missing `din_stb` pulse within two edges of the write-enable or column fall, together with a wrong `cyc_type` code.

// File: rtl/dsd_pkg.sv
package dsd_pkg;
  localparam int unsigned NSTROBE = 4;
  localparam int unsigned S_RAS   = 0;
  localparam int unsigned S_CAS   = 1;
  localparam int unsigned S_WE    = 2;
  localparam int unsigned S_OE    = 3;

  typedef enum logic [2:0] {
    CYC_IDLE    = 3'd0,
    CYC_READ    = 3'd1,
    CYC_EARLYWR = 3'd2,
    CYC_LATEWR  = 3'd3,
    CYC_ROWONLY = 3'd4,
    CYC_CBR     = 3'd5,
    CYC_HIDDEN  = 3'd6
  } cyc_e;
endpackage

// File: rtl/dsd_rst_sync.sv
module dsd_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      srst_n <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      srst_n <= meta_q;
    end
  end
endmodule

// File: rtl/dsd_sampler.sv
module dsd_sampler #(
  parameter int unsigned NS = 4,
  parameter int unsigned AW = 10
) (
  input  logic          clk,
  input  logic          srst_n,
  input  logic [NS-1:0] pins_n,
  input  logic [AW-1:0] addr_in,
  output logic [NS-1:0] cur_n,
  output logic [NS-1:0] fall,
  output logic [NS-1:0] rise,
  output logic [AW-1:0] addr_cur
);
  logic [NS-1:0] prv_n;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      cur_n    <= '1;
      prv_n    <= '1;
      addr_cur <= '0;
    end else begin
      cur_n    <= pins_n;
      prv_n    <= cur_n;
      addr_cur <= addr_in;
    end
  end

  for (genvar i = 0; i < NS; i++) begin : g_edge
    assign fall[i] = prv_n[i] & ~cur_n[i];
    assign rise[i] = ~prv_n[i] & cur_n[i];

    a_r11_single_edge: assert property (@(posedge clk) disable iff (!srst_n)
      fall[i] |=> !fall[i]);
  end
endmodule

// File: rtl/dsd_refresh_ctr.sv
module dsd_refresh_ctr #(
  parameter int unsigned ROWS = 1024,
  localparam int unsigned AW  = $clog2(ROWS)
) (
  input  logic          clk,
  input  logic          srst_n,
  input  logic          inc,
  output logic [AW-1:0] count
);
  localparam logic [AW-1:0] LAST = AW'(ROWS - 1);
  logic [AW-1:0] count_d;

  always_comb begin
    count_d = count;
    if (inc) count_d = (count == LAST) ? '0 : count + 1'b1;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)  count <= '0;
    else if (inc) count <= count_d;
  end

  a_r10_step_wrap: assert property (@(posedge clk) disable iff (!srst_n)
    inc |=> count == (($past(count) == LAST) ? '0 : $past(count) + 1'b1));

  a_r10_hold: assert property (@(posedge clk) disable iff (!srst_n)
    !inc |=> $stable(count));
endmodule

// File: rtl/dsd_classifier.sv
module dsd_classifier
  import dsd_pkg::*;
#(
  parameter int unsigned AW = 10
) (
  input  logic               clk,
  input  logic               srst_n,
  input  logic [NSTROBE-1:0] cur_n,
  input  logic [NSTROBE-1:0] fall,
  input  logic [NSTROBE-1:0] rise,
  input  logic [AW-1:0]      addr_cur,
  input  logic [AW-1:0]      ref_row,
  output logic               ref_inc,
  output logic [AW-1:0]      row_addr,
  output logic               row_stb,
  output logic               din_stb,
  output logic               dq_oe,
  output cyc_e               cyc
);
  logic ras_lo, cas_lo, we_lo, oe_lo;
  logic ras_f, ras_r, cas_f, cas_r, we_f;
  logic unused_edges;

  assign ras_lo = ~cur_n[S_RAS];
  assign cas_lo = ~cur_n[S_CAS];
  assign we_lo  = ~cur_n[S_WE];
  assign oe_lo  = ~cur_n[S_OE];
  assign ras_f  = fall[S_RAS];
  assign ras_r  = rise[S_RAS];
  assign cas_f  = fall[S_CAS];
  assign cas_r  = rise[S_CAS];
  assign we_f   = fall[S_WE];
  assign unused_edges = ^{fall[S_OE], rise[S_WE], rise[S_OE]};

  cyc_e          cyc_d;
  logic          open_q, open_d;
  logic          rdv_q, rdv_d;
  logic          hold_q, hold_d;
  logic [AW-1:0] row_d;
  logic          row_stb_d, din_d, oe_d;

  always_comb begin
    cyc_d     = cyc;
    open_d    = open_q;
    rdv_d     = rdv_q;
    hold_d    = hold_q;
    row_d     = row_addr;
    row_stb_d = 1'b0;
    din_d     = 1'b0;
    ref_inc   = 1'b0;

    if (ras_f) begin
      row_stb_d = 1'b1;
      if (cas_lo) begin
        cyc_d   = hold_q ? CYC_HIDDEN : CYC_CBR;
        row_d   = ref_row;
        ref_inc = 1'b1;
        open_d  = 1'b0;
      end else begin
        cyc_d  = CYC_ROWONLY;
        row_d  = addr_cur;
        open_d = 1'b1;
      end
    end

    if (ras_r) begin
      open_d = 1'b0;
      if (cas_lo && rdv_q) hold_d = 1'b1;
    end
    if (cas_r) hold_d = 1'b0;

    if (cas_f && open_q && ras_lo) begin
      if (we_lo) begin
        cyc_d = CYC_EARLYWR;
        din_d = 1'b1;
        rdv_d = 1'b0;
      end else begin
        cyc_d = CYC_READ;
        rdv_d = 1'b1;
      end
    end

    if (we_f && !cas_f) begin
      if (cas_lo && open_q && ras_lo && cyc == CYC_READ) begin
        cyc_d = CYC_LATEWR;
        din_d = 1'b1;
        rdv_d = 1'b0;
      end else if (!cas_lo) begin
        rdv_d = 1'b0;
      end
    end

    if (!ras_lo && !cas_lo) begin
      rdv_d  = 1'b0;
      hold_d = 1'b0;
    end

    oe_d = rdv_d & oe_lo;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      cyc      <= CYC_IDLE;
      open_q   <= 1'b0;
      rdv_q    <= 1'b0;
      hold_q   <= 1'b0;
      row_addr <= '0;
      row_stb  <= 1'b0;
      din_stb  <= 1'b0;
      dq_oe    <= 1'b0;
    end else begin
      cyc      <= cyc_d;
      open_q   <= open_d;
      rdv_q    <= rdv_d;
      hold_q   <= hold_d;
      row_stb  <= row_stb_d;
      din_stb  <= din_d;
      dq_oe    <= oe_d;
      if (row_stb_d) row_addr <= row_d;
    end
  end

  a_r2_row_pulse: assert property (@(posedge clk) disable iff (!srst_n)
    row_stb |=> !row_stb);

  a_r3_strobe_only_write: assert property (@(posedge clk) disable iff (!srst_n)
    din_stb |-> (cyc == CYC_EARLYWR || cyc == CYC_LATEWR));

  a_r5_early_no_drive: assert property (@(posedge clk) disable iff (!srst_n)
    (cyc == CYC_EARLYWR) |-> !dq_oe);

  a_r2_rowonly_no_drive: assert property (@(posedge clk) disable iff (!srst_n)
    (cyc == CYC_ROWONLY) |-> !dq_oe);

  a_r7_counter_row: assert property (@(posedge clk) disable iff (!srst_n)
    (row_stb && (cyc == CYC_CBR || cyc == CYC_HIDDEN)) |-> row_addr == $past(ref_row));

  a_r6_single_strobe: assert property (@(posedge clk) disable iff (!srst_n)
    din_stb |=> !din_stb);
endmodule

// File: rtl/dram_strobe_decoder.sv
module dram_strobe_decoder
  import dsd_pkg::*;
#(
  parameter int unsigned ROWS = 1024,
  localparam int unsigned AW  = $clog2(ROWS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ras_n,
  input  logic          cas_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic [AW-1:0] row_in,
  output logic [AW-1:0] row_addr,
  output logic          row_stb,
  output logic          din_stb,
  output logic          dq_oe,
  output logic [2:0]    cyc_type
);
  logic               srst_n;
  logic [NSTROBE-1:0] pins_n, cur_n, fall, rise;
  logic [AW-1:0]      addr_cur, ref_row;
  logic               ref_inc;
  cyc_e               cyc;

  assign pins_n[S_RAS] = ras_n;
  assign pins_n[S_CAS] = cas_n;
  assign pins_n[S_WE]  = we_n;
  assign pins_n[S_OE]  = oe_n;
  assign cyc_type      = cyc;

  dsd_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  dsd_sampler #(.NS(NSTROBE), .AW(AW)) u_smp (
    .clk      (clk),
    .srst_n   (srst_n),
    .pins_n   (pins_n),
    .addr_in  (row_in),
    .cur_n    (cur_n),
    .fall     (fall),
    .rise     (rise),
    .addr_cur (addr_cur)
  );

  dsd_refresh_ctr #(.ROWS(ROWS)) u_ctr (
    .clk    (clk),
    .srst_n (srst_n),
    .inc    (ref_inc),
    .count  (ref_row)
  );

  dsd_classifier #(.AW(AW)) u_cls (
    .clk      (clk),
    .srst_n   (srst_n),
    .cur_n    (cur_n),
    .fall     (fall),
    .rise     (rise),
    .addr_cur (addr_cur),
    .ref_row  (ref_row),
    .ref_inc  (ref_inc),
    .row_addr (row_addr),
    .row_stb  (row_stb),
    .din_stb  (din_stb),
    .dq_oe    (dq_oe),
    .cyc      (cyc)
  );
endmodule

// File: tb/sim_dram_strobe_decoder.sv
module sim_dram_strobe_decoder;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [9:0] row_in = '0;
  logic [9:0] row_addr;
  logic       row_stb, din_stb, dq_oe;
  logic [2:0] cyc_type;

  int tests = 0, fails = 0;
  int row_cnt = 0, din_cnt = 0, last_row = 0;
  int mcnt = 0;

  always #5 clk = ~clk;

  dram_strobe_decoder u0 (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .oe_n(oe_n), .row_in(row_in), .row_addr(row_addr), .row_stb(row_stb),
    .din_stb(din_stb), .dq_oe(dq_oe), .cyc_type(cyc_type)
  );

  always @(negedge clk) begin
    if (row_stb) begin
      row_cnt++;
      last_row = int'(row_addr);
    end
    if (din_stb) din_cnt++;
  end

  function automatic int next_row(input int r);
    return (r + 1) % 1024;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input logic r, input logic c, input logic w, input logic o);
    ras_n = r; cas_n = c; we_n = w; oe_n = o;
    repeat (3) @(negedge clk);
  endtask

  task automatic do_read(input logic [9:0] a, input logic o);
    int d0 = din_cnt;
    int r0 = row_cnt;
    row_in = a;
    step(1, 1, 1, o);
    step(0, 1, 1, o);
    chk("R2 row pulse count", row_cnt - r0, 1);
    chk("R2 row addr", last_row, int'(a));
    step(0, 0, 1, o);
    chk("R3 type read", int'(cyc_type), 1);
    chk("R3 dq_oe", int'(dq_oe), int'(!o));
    step(0, 1, 1, o);
    chk("R4 extended hold", int'(dq_oe), int'(!o));
    step(1, 1, 1, o);
    chk("R4 off when both high", int'(dq_oe), 0);
    chk("R3 no data strobe", din_cnt - d0, 0);
  endtask

  task automatic do_early(input logic [9:0] a, input logic o);
    int d0 = din_cnt;
    row_in = a;
    step(1, 1, 0, o);
    step(0, 1, 0, o);
    chk("R2 early row addr", last_row, int'(a));
    step(0, 0, 0, o);
    chk("R5 type early", int'(cyc_type), 2);
    chk("R5 one strobe", din_cnt - d0, 1);
    chk("R5 dq off", int'(dq_oe), 0);
    step(0, 1, 0, o);
    step(1, 1, 1, o);
    chk("R5 no extra strobe", din_cnt - d0, 1);
  endtask

  task automatic do_late(input logic [9:0] a);
    int d0 = din_cnt;
    row_in = a;
    step(0, 1, 1, 1);
    step(0, 0, 1, 1);
    chk("R6 read phase type", int'(cyc_type), 1);
    chk("R6 no strobe at cas fall", din_cnt - d0, 0);
    step(0, 0, 0, 1);
    chk("R6 type late", int'(cyc_type), 3);
    chk("R6 strobe at we fall", din_cnt - d0, 1);
    chk("R6 dq off", int'(dq_oe), 0);
    step(0, 1, 0, 1);
    step(1, 1, 1, 1);
  endtask

  task automatic do_rowonly(input logic [9:0] a);
    row_in = a;
    step(0, 1, 1, 0);
    step(1, 1, 1, 0);
    chk("R2 type row-only", int'(cyc_type), 4);
    chk("R2 row-only addr", last_row, int'(a));
    chk("R2 row-only dq off", int'(dq_oe), 0);
  endtask

  task automatic do_cbr(input logic [9:0] a, input int n);
    row_in = a;
    step(1, 0, 1, 1);
    for (int i = 0; i < n; i++) begin
      step(0, 0, 1, 1);
      chk(i == 0 ? "R7 type cbr" : "R8 back-to-back type", int'(cyc_type), 5);
      chk(i == 0 ? "R7 counter row" : "R8 counter row", last_row, mcnt);
      mcnt = next_row(mcnt);
      step(1, 0, 1, 1);
    end
    step(1, 1, 1, 1);
  endtask

  task automatic do_hidden(input logic [9:0] a);
    row_in = a;
    step(0, 1, 1, 0);
    step(0, 0, 1, 0);
    chk("R9 read dq on", int'(dq_oe), 1);
    step(1, 0, 1, 0);
    chk("R9 dq held", int'(dq_oe), 1);
    step(0, 0, 1, 0);
    chk("R9 type hidden", int'(cyc_type), 6);
    chk("R9 counter row", last_row, mcnt);
    chk("R9 dq during refresh", int'(dq_oe), 1);
    mcnt = next_row(mcnt);
    step(1, 0, 1, 0);
    step(1, 1, 1, 0);
    chk("R9 dq off at end", int'(dq_oe), 0);
  endtask

  task automatic do_edo_wdis(input logic [9:0] a);
    int d0 = din_cnt;
    row_in = a;
    step(0, 1, 1, 0);
    step(0, 0, 1, 0);
    step(0, 1, 1, 0);
    chk("R4 hold before we", int'(dq_oe), 1);
    step(0, 1, 0, 0);
    chk("R4 we fall disables", int'(dq_oe), 0);
    chk("R4 no strobe", din_cnt - d0, 0);
    step(1, 1, 1, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R11 watchdog expired actual=0 expected=1");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int r0;
    void'($urandom(32'd2024));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 reset type", int'(cyc_type), 0);
    chk("R1 reset dq", int'(dq_oe), 0);
    chk("R1 reset pulses", row_cnt + din_cnt, 0);

    // R11: output appears one edge after the sampling edge
    r0 = row_cnt;
    row_in = 10'd77;
    ras_n = 1'b0;
    @(negedge clk);
    chk("R11 not yet after first edge", int'(row_stb), 0);
    @(negedge clk);
    chk("R11 pulse after second edge", int'(row_stb), 1);
    @(negedge clk);
    chk("R11 pulse one cycle", int'(row_stb), 0);
    step(1, 1, 1, 1);
    chk("R2 directed row-only", int'(cyc_type), 4);
    chk("R2 single pulse", row_cnt - r0, 1);

    do_cbr(10'h3aa, 1);
    do_read(10'd5, 1'b0);
    do_read(10'd1023, 1'b1);
    do_early(10'd12, 1'b0);
    do_late(10'd300);
    do_rowonly(10'd0);
    do_hidden(10'd44);
    do_edo_wdis(10'd9);
    do_cbr(10'd1, 3);

    for (int k = 0; k < 40; k++) begin
      logic [9:0] a;
      logic       o;
      a = 10'($urandom);
      o = 1'($urandom);
      case ($urandom % 7)
        0: do_read(a, o);
        1: do_early(a, o);
        2: do_late(a);
        3: do_rowonly(a);
        4: do_cbr(a, 1 + int'($urandom % 3));
        5: do_hidden(a);
        default: do_edo_wdis(a);
      endcase
    end

    // R10: run the counter through its wrap with back-to-back refreshes
    step(1, 0, 1, 1);
    while (mcnt != 0) begin
      int exp_row = mcnt;
      step(0, 0, 1, 1);
      if (exp_row >= 1022) chk("R10 row near top", last_row, exp_row);
      mcnt = next_row(mcnt);
      step(1, 0, 1, 1);
    end
    step(0, 0, 1, 1);
    chk("R10 wrapped to zero", last_row, 0);
    mcnt = next_row(mcnt);
    step(1, 0, 1, 1);
    step(1, 1, 1, 1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule